// File: doc/BRIEF.md
# Sequential Stream Prefetch Buffer

This block sits next to a small direct-mapped cache, on the path between that cache and the next memory level. Every cache miss is presented to it first. It keeps a short in-order queue of blocks fetched ahead of demand, and only the oldest queued block is compared against the miss address. When the oldest block matches, it goes straight back to the cache and leaves the queue. The freed slot is then refilled with the next consecutive block address.

When the oldest block does not match, the queue is emptied and the missing block is fetched from the next level as a demand transfer. Once that block has been delivered, the stream restarts at the following block address. The block does not care whether the stream carries instructions or data. It is placed once per stream, beside either kind of cache.

The next-level port carries one transfer at a time. A request is held until it is accepted, and a response may come any number of cycles later. A prefetch response that arrives after its stream was flushed is dropped.

Top module: `spb_stream_buf`

## Requirements
- R1: After reset, `miss_ready` is 1, `ret_valid` is 0 and `mem_req_valid` is 0. No next-level request is made before the first miss has been served.
- R2: A miss whose block address equals the oldest queued tag, with that entry's data already present, produces `ret_valid`=1 with `ret_hit`=1 in the following cycle. It returns that entry's data and causes no next-level request for that address.
- R3: A miss that does not match the oldest entry, or that arrives while the queue is empty, invalidates every entry. It then issues a next-level request for the miss address and returns the response data with `ret_hit`=0.
- R4: After a demand block at address A is delivered, prefetch requests go out for A+1, A+2 and onward. This continues until DEPTH entries are occupied; no entry is allocated beyond DEPTH.
- R5: Each time a hit removes the oldest entry, exactly one new prefetch is issued. Its address is one more than the last prefetched address.
- R6: At most one next-level transfer is in flight. While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request and its address stay unchanged in the next cycle.
- R7: A miss that matches the oldest entry while that entry's data is still in flight does not respond at once. It returns with `ret_hit`=1 and the response data as soon as the response arrives.
- R8: A prefetch response that belongs to a stream flushed before it arrived is never returned and never produces a hit. A later miss to that address gets `ret_hit`=0.
- R9: Only the oldest entry is compared. A miss equal to a younger valid entry is treated as a non-match under R3, and its address is the next request sent.
- R10: Block addresses for prefetching wrap modulo 2^BLK_AW, so the block after the all-ones address is address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Cache presents a miss this cycle |
| miss_addr | input | BLK_AW | Block address of the miss |
| miss_ready | output | 1 | Buffer can take a miss this cycle |
| ret_valid | output | 1 | One-cycle pulse: block for the accepted miss |
| ret_hit | output | 1 | 1 if the block came from the queue, 0 if fetched on demand |
| ret_data | output | BLK_W | Returned block |
| mem_req_valid | output | 1 | Request to the next level |
| mem_req_addr | output | BLK_AW | Block address requested |
| mem_req_ready | input | 1 | Next level accepts the request |
| mem_rsp_valid | input | 1 | Next level returns the block of the accepted request |
| mem_rsp_data | input | BLK_W | Block returned by the next level |

## Verification
The bench sends a miss to a block that sits deeper in the queue than the oldest entry. A design that compared every entry would report a hit there instead of flushing and fetching on demand. It also sends a miss while the matching block is still in flight, and then flushes the stream while a prefetch is outstanding. A wrong design would either answer with stale data or deadlock in the first case, and would let the dropped block surface later as a false hit in the second. Further runs cover address wrap past the all-ones block and a next level that stalls its ready signal. An incrementer without wrap would request the wrong block, and a port that changed its request under stall would break the strict request order the bench records.

// File: rtl/spb_pkg.sv
package spb_pkg;

   // Control states of the buffer front end
   typedef enum logic [1:0] {
      ST_IDLE        = 2'd0,
      ST_WAIT_HEAD   = 2'd1,
      ST_DEMAND_REQ  = 2'd2,
      ST_DEMAND_WAIT = 2'd3
   } spb_state_e;

   // Kind of the transfer currently owned by the next-level port
   typedef enum logic [1:0] {
      XF_NONE     = 2'd0,
      XF_DEMAND   = 2'd1,
      XF_PREFETCH = 2'd2,
      XF_DROP     = 2'd3
   } spb_xfer_e;

   // Phase of the next-level port
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_REQ  = 2'd1,
      PH_WAIT = 2'd2
   } spb_phase_e;

endpackage

// File: rtl/spb_entry_fifo.sv
module spb_entry_fifo #(
   parameter int DEPTH  = 4,
   parameter int TAG_W  = 16,
   parameter int DATA_W = 64,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push,
   input  logic [TAG_W-1:0]  push_tag,
   input  logic              fill,
   input  logic [IDX_W-1:0]  fill_idx,
   input  logic [DATA_W-1:0] fill_data,
   input  logic              pop,
   output logic              head_valid,
   output logic              head_pend,
   output logic [TAG_W-1:0]  head_tag,
   output logic [DATA_W-1:0] head_data,
   output logic [IDX_W-1:0]  head_idx,
   output logic [IDX_W-1:0]  tail_idx,
   output logic [CNT_W-1:0]  count,
   output logic              full
);

   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   if (DEPTH < 2) begin : g_bad_depth
      $error("spb_entry_fifo: DEPTH must be at least 2");
   end

   logic [IDX_W-1:0] head_q, tail_q, head_nxt, tail_nxt;
   logic [CNT_W-1:0] cnt_q;

   logic              ent_v [DEPTH];
   logic              ent_p [DEPTH];
   logic [TAG_W-1:0]  ent_t [DEPTH];
   logic [DATA_W-1:0] ent_d [DEPTH];

   // Pointer advance: free wrap for power-of-two depths, compare otherwise
   if (POW2) begin : g_wrap_pow2
      assign head_nxt = head_q + 1'b1;
      assign tail_nxt = tail_q + 1'b1;
   end else begin : g_wrap_cmp
      assign head_nxt = (head_q == IDX_W'(DEPTH - 1)) ? '0 : head_q + 1'b1;
      assign tail_nxt = (tail_q == IDX_W'(DEPTH - 1)) ? '0 : tail_q + 1'b1;
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic              v_q, p_q;
      logic [TAG_W-1:0]  t_q;
      logic [DATA_W-1:0] d_q;
      logic              sel_push, sel_fill, sel_pop;

      assign sel_push = push && (tail_q == IDX_W'(i));
      assign sel_fill = fill && (fill_idx == IDX_W'(i));
      assign sel_pop  = pop && (head_q == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            p_q <= 1'b0;
            t_q <= '0;
            d_q <= '0;
         end else if (flush) begin
            v_q <= 1'b0;
            p_q <= 1'b0;
         end else begin
            if (sel_push) begin
               v_q <= 1'b1;
               p_q <= 1'b1;
               t_q <= push_tag;
            end
            if (sel_fill) begin
               p_q <= 1'b0;
               d_q <= fill_data;
            end
            if (sel_pop) begin
               v_q <= 1'b0;
               p_q <= 1'b0;
            end
         end
      end

      assign ent_v[i] = v_q;
      assign ent_p[i] = p_q;
      assign ent_t[i] = t_q;
      assign ent_d[i] = d_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= '0;
      end else if (flush) begin
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (push) tail_q <= tail_nxt;
         if (pop)  head_q <= head_nxt;
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign head_valid = ent_v[head_q];
   assign head_pend  = ent_p[head_q];
   assign head_tag   = ent_t[head_q];
   assign head_data  = ent_d[head_q];
   assign head_idx   = head_q;
   assign tail_idx   = tail_q;
   assign count      = cnt_q;
   assign full       = (cnt_q == CNT_W'(DEPTH));

   // R4
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop) |-> !full);

   // R2
   pop_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !flush) |-> head_valid);

endmodule

// File: rtl/spb_next_addr.sv
module spb_next_addr #(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] base,
   input  logic          step,
   output logic [AW-1:0] pf_addr
);

   if (AW < 2) begin : g_bad_aw
      $error("spb_next_addr: AW must be at least 2");
   end

   logic [AW-1:0] pf_q;

   // Block increment wraps modulo 2^AW
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pf_q <= '0;
      else if (load)  pf_q <= base + 1'b1;
      else if (step)  pf_q <= pf_q + 1'b1;
   end

   assign pf_addr = pf_q;

endmodule

// File: rtl/spb_mem_port.sv
module spb_mem_port
   import spb_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          issue,
   input  logic          issue_demand,
   input  logic [AW-1:0] issue_addr,
   input  logic          drop,
   output logic          busy,
   output logic          rsp_demand,
   output logic          rsp_prefetch,
   output logic [DW-1:0] rsp_data,
   output logic          mem_req_valid,
   output logic [AW-1:0] mem_req_addr,
   input  logic          mem_req_ready,
   input  logic          mem_rsp_valid,
   input  logic [DW-1:0] mem_rsp_data
);

   spb_phase_e    ph_q;
   spb_xfer_e     kind_q;
   logic [AW-1:0] addr_q;
   logic          rsp_fire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         kind_q <= XF_NONE;
         addr_q <= '0;
      end else begin
         case (ph_q)
            PH_IDLE: if (issue) begin
               ph_q   <= PH_REQ;
               addr_q <= issue_addr;
               kind_q <= issue_demand ? XF_DEMAND : XF_PREFETCH;
            end
            PH_REQ:  if (mem_req_ready) ph_q <= PH_WAIT;
            PH_WAIT: if (mem_rsp_valid) begin
               ph_q   <= PH_IDLE;
               kind_q <= XF_NONE;
            end
            default: ph_q <= PH_IDLE;
         endcase
         // a flushed stream keeps the transfer but discards its block
         if (drop && (ph_q != PH_IDLE) && (kind_q == XF_PREFETCH) &&
             !(ph_q == PH_WAIT && mem_rsp_valid))
            kind_q <= XF_DROP;
      end
   end

   assign busy          = (ph_q != PH_IDLE);
   assign mem_req_valid = (ph_q == PH_REQ);
   assign mem_req_addr  = addr_q;
   assign rsp_fire      = mem_rsp_valid && (ph_q == PH_WAIT);
   assign rsp_demand    = rsp_fire && (kind_q == XF_DEMAND);
   assign rsp_prefetch  = rsp_fire && (kind_q == XF_PREFETCH) && !drop;
   assign rsp_data      = mem_rsp_data;

   // R6
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   // R6
   issue_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue |-> !busy);

   // R8
   drop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && kind_q == XF_DROP) |-> !(rsp_demand || rsp_prefetch));

endmodule

// File: rtl/spb_stream_buf.sv
module spb_stream_buf
   import spb_pkg::*;
#(
   parameter int BLK_AW = 16,
   parameter int BLK_W  = 64,
   parameter int DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              miss_valid,
   input  logic [BLK_AW-1:0] miss_addr,
   output logic              miss_ready,
   output logic              ret_valid,
   output logic              ret_hit,
   output logic [BLK_W-1:0]  ret_data,
   output logic              mem_req_valid,
   output logic [BLK_AW-1:0] mem_req_addr,
   input  logic              mem_req_ready,
   input  logic              mem_rsp_valid,
   input  logic [BLK_W-1:0]  mem_rsp_data
);

   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (BLK_W < 1) begin : g_bad_w
      $error("spb_stream_buf: BLK_W must be positive");
   end
   if (DEPTH < 2) begin : g_bad_d
      $error("spb_stream_buf: DEPTH must be at least 2");
   end

   spb_state_e        st_q;
   logic [BLK_AW-1:0] dem_addr_q;
   logic [IDX_W-1:0]  fill_idx_q;
   logic              pf_live_q;
   logic              ret_v_q, ret_h_q;
   logic [BLK_W-1:0]  ret_d_q;

   logic              head_valid, head_pend, full;
   logic [BLK_AW-1:0] head_tag;
   logic [BLK_W-1:0]  head_data;
   logic [IDX_W-1:0]  head_idx, tail_idx;
   logic [CNT_W-1:0]  fifo_cnt;

   logic              busy, rsp_demand, rsp_prefetch;
   logic [BLK_W-1:0]  rsp_data;
   logic [BLK_AW-1:0] pf_addr;

   logic miss_fire, head_match, fill_head_now, head_avail;
   logic take_hit, wait_hit, take_miss, head_done;
   logic pf_issue, dem_issue, do_issue, do_pop;
   logic [BLK_AW-1:0] issue_addr;
   logic [BLK_W-1:0]  head_word;

   // Lookup: only the oldest entry is compared
   assign miss_fire     = miss_valid && (st_q == ST_IDLE);
   assign head_match    = head_valid && (head_tag == miss_addr);
   assign fill_head_now = rsp_prefetch && (fill_idx_q == head_idx);
   assign head_avail    = !head_pend || fill_head_now;
   assign head_word     = head_pend ? rsp_data : head_data;
   assign take_hit      = miss_fire && head_match && head_avail;
   assign wait_hit      = miss_fire && head_match && !head_avail;
   assign take_miss     = miss_fire && !head_match;
   assign head_done     = (st_q == ST_WAIT_HEAD) && rsp_prefetch;

   // Transfer scheduling: one engine shared by demand and prefetch
   assign pf_issue   = pf_live_q && (st_q == ST_IDLE) && !take_miss && !busy && !full;
   assign dem_issue  = (st_q == ST_DEMAND_REQ) && !busy;
   assign do_issue   = pf_issue || dem_issue;
   assign issue_addr = dem_issue ? dem_addr_q : pf_addr;
   assign do_pop     = take_hit || head_done;

   spb_entry_fifo #(
      .DEPTH  (DEPTH),
      .TAG_W  (BLK_AW),
      .DATA_W (BLK_W)
   ) i_fifo (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (take_miss),
      .push       (pf_issue),
      .push_tag   (pf_addr),
      .fill       (rsp_prefetch),
      .fill_idx   (fill_idx_q),
      .fill_data  (rsp_data),
      .pop        (do_pop),
      .head_valid (head_valid),
      .head_pend  (head_pend),
      .head_tag   (head_tag),
      .head_data  (head_data),
      .head_idx   (head_idx),
      .tail_idx   (tail_idx),
      .count      (fifo_cnt),
      .full       (full)
   );

   spb_next_addr #(
      .AW (BLK_AW)
   ) i_next (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (rsp_demand),
      .base    (dem_addr_q),
      .step    (pf_issue),
      .pf_addr (pf_addr)
   );

   spb_mem_port #(
      .AW (BLK_AW),
      .DW (BLK_W)
   ) i_port (
      .clk           (clk),
      .rst_n         (rst_n),
      .issue         (do_issue),
      .issue_demand  (dem_issue),
      .issue_addr    (issue_addr),
      .drop          (take_miss),
      .busy          (busy),
      .rsp_demand    (rsp_demand),
      .rsp_prefetch  (rsp_prefetch),
      .rsp_data      (rsp_data),
      .mem_req_valid (mem_req_valid),
      .mem_req_addr  (mem_req_addr),
      .mem_req_ready (mem_req_ready),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         dem_addr_q <= '0;
         fill_idx_q <= '0;
         pf_live_q  <= 1'b0;
         ret_v_q    <= 1'b0;
         ret_h_q    <= 1'b0;
         ret_d_q    <= '0;
      end else begin
         ret_v_q <= 1'b0;
         if (pf_issue) fill_idx_q <= tail_idx;
         case (st_q)
            ST_IDLE: begin
               if (take_hit) begin
                  ret_v_q <= 1'b1;
                  ret_h_q <= 1'b1;
                  ret_d_q <= head_word;
               end else if (wait_hit) begin
                  st_q <= ST_WAIT_HEAD;
               end else if (take_miss) begin
                  dem_addr_q <= miss_addr;
                  st_q       <= ST_DEMAND_REQ;
               end
            end
            ST_WAIT_HEAD: if (head_done) begin
               ret_v_q <= 1'b1;
               ret_h_q <= 1'b1;
               ret_d_q <= rsp_data;
               st_q    <= ST_IDLE;
            end
            ST_DEMAND_REQ: if (dem_issue) st_q <= ST_DEMAND_WAIT;
            ST_DEMAND_WAIT: if (rsp_demand) begin
               ret_v_q   <= 1'b1;
               ret_h_q   <= 1'b0;
               ret_d_q   <= rsp_data;
               pf_live_q <= 1'b1;
               st_q      <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign miss_ready = (st_q == ST_IDLE);
   assign ret_valid  = ret_v_q;
   assign ret_hit    = ret_h_q;
   assign ret_data   = ret_d_q;

   // R2
   hit_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_hit |=> (ret_valid && ret_hit));

   // R3
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_miss |=> (fifo_cnt == '0));

   // R3
   miss_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_valid && !ret_hit) |-> $past(rsp_demand));

   // R7
   wait_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_WAIT_HEAD) |-> (head_valid && head_pend));

   // R1
   no_early_pf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pf_live_q |-> !(mem_req_valid && fifo_cnt != '0));

endmodule

// File: tb/test_spb_stream_buf.sv
`timescale 1ns/1ps
module test_spb_stream_buf;

   localparam int AW = 16;
   localparam int BW = 64;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          miss_valid;
   logic [AW-1:0] miss_addr;
   logic          miss_ready;
   logic          ret_valid, ret_hit;
   logic [BW-1:0] ret_data;
   logic          mem_req_valid;
   logic [AW-1:0] mem_req_addr;
   logic          mem_req_ready;
   logic          mem_rsp_valid;
   logic [BW-1:0] mem_rsp_data;

   always #2.5 clk = ~clk;

   spb_stream_buf #(.BLK_AW(AW), .BLK_W(BW), .DEPTH(4)) i_spb_stream_buf (
      .clk           (clk),
      .rst_n         (rst_n),
      .miss_valid    (miss_valid),
      .miss_addr     (miss_addr),
      .miss_ready    (miss_ready),
      .ret_valid     (ret_valid),
      .ret_hit       (ret_hit),
      .ret_data      (ret_data),
      .mem_req_valid (mem_req_valid),
      .mem_req_addr  (mem_req_addr),
      .mem_req_ready (mem_req_ready),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data)
   );

   int n_chk = 0;
   int n_bad = 0;
   int last_wait = 0;

   // next-level model state
   int            lat = 2;
   bit            stall_mode = 1'b0;
   bit            have = 1'b0;
   int            cd = 0;
   int            phase = 0;
   logic [AW-1:0] paddr = '0;
   logic [AW-1:0] req_log [0:255];
   int            req_n = 0;

   function automatic logic [BW-1:0] blk(input logic [AW-1:0] a);
      return {a ^ 16'h5a5a, 16'hc0de, ~a, a};
   endfunction

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [BW-1:0] act, input logic [BW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   // Next-level memory: accepts at negedge view, answers after lat cycles
   initial begin
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = '0;
      mem_req_ready = 1'b1;
      forever begin
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         if (have) begin
            if (cd == 0) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_data  = blk(paddr);
               have = 1'b0;
            end else begin
               cd--;
            end
         end
         phase++;
         mem_req_ready = stall_mode ? (phase % 3 == 0) : 1'b1;
         if (rst_n && mem_req_valid && mem_req_ready && !have && !mem_rsp_valid) begin
            have  = 1'b1;
            paddr = mem_req_addr;
            cd    = lat;
            if (req_n < 256) req_log[req_n] = mem_req_addr;
            req_n++;
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_miss(input logic [AW-1:0] a, input bit exp_hit, input string rq);
      int waited = 0;
      while (!miss_ready) @(negedge clk);
      miss_valid = 1'b1;
      miss_addr  = a;
      @(negedge clk);
      miss_valid = 1'b0;
      while (!ret_valid && waited < 500) begin
         @(negedge clk);
         waited++;
      end
      last_wait = waited;
      chk(ret_valid == 1'b1, rq, "return arrived", BW'(ret_valid), BW'(1));
      chk(ret_hit == exp_hit, rq, "hit flag", BW'(ret_hit), BW'(exp_hit));
      chk(ret_data == blk(a), rq, "block data", ret_data, blk(a));
   endtask

   task automatic check_req(input int idx, input logic [AW-1:0] exp, input string rq);
      logic [AW-1:0] act;
      act = (idx < req_n && idx < 256) ? req_log[idx] : 'x;
      chk(idx < req_n && act == exp, rq, "request address", BW'(act), BW'(exp));
   endtask

   task automatic t_reset;
      idle(4);
      chk(miss_ready == 1'b1, "R1", "miss_ready", BW'(miss_ready), BW'(1));
      chk(ret_valid == 1'b0, "R1", "ret_valid", BW'(ret_valid), BW'(0));
      chk(mem_req_valid == 1'b0, "R1", "mem_req_valid", BW'(mem_req_valid), BW'(0));
      chk(req_n == 0, "R1", "requests before first miss", BW'(req_n), BW'(0));
   endtask

   task automatic t_cold_fill;
      int base;
      idle(20);
      base = req_n;
      do_miss(16'h0100, 1'b0, "R3");
      idle(40);
      check_req(base, 16'h0100, "R3");
      for (int k = 1; k <= 4; k++) check_req(base + k, 16'h0100 + AW'(k), "R4");
      chk(req_n == base + 5, "R4", "fill stops at depth", BW'(req_n), BW'(base + 5));
   endtask

   task automatic t_hit_refill;
      int base;
      idle(20);
      base = req_n;
      do_miss(16'h0101, 1'b1, "R2");
      idle(20);
      chk(req_n == base + 1, "R5", "one refill per hit", BW'(req_n), BW'(base + 1));
      check_req(base, 16'h0105, "R5");
      do_miss(16'h0102, 1'b1, "R2");
      do_miss(16'h0103, 1'b1, "R2");
      do_miss(16'h0104, 1'b1, "R2");
   endtask

   task automatic t_nonhead;
      int base;
      idle(30);
      base = req_n;
      do_miss(16'h0107, 1'b0, "R9");
      idle(30);
      check_req(base, 16'h0107, "R9");
      check_req(base + 1, 16'h0108, "R4");
   endtask

   task automatic t_pending_then_drop;
      idle(20);
      lat = 20;
      do_miss(16'h2000, 1'b0, "R3");
      idle(3);
      do_miss(16'h2001, 1'b1, "R7");
      chk(last_wait > 5, "R7", "waited for in-flight block", BW'(last_wait), BW'(6));
      idle(3);
      lat = 1;
      do_miss(16'h3000, 1'b0, "R8");
      idle(30);
      do_miss(16'h3001, 1'b1, "R8");
      do_miss(16'h2002, 1'b0, "R8");
   endtask

   task automatic t_wrap;
      int base;
      idle(20);
      base = req_n;
      do_miss(16'hFFFF, 1'b0, "R10");
      idle(30);
      check_req(base, 16'hFFFF, "R10");
      check_req(base + 1, 16'h0000, "R10");
      do_miss(16'h0000, 1'b1, "R10");
   endtask

   task automatic t_stall;
      int base;
      idle(20);
      stall_mode = 1'b1;
      base = req_n;
      do_miss(16'h4000, 1'b0, "R6");
      idle(80);
      for (int k = 0; k <= 4; k++) check_req(base + k, 16'h4000 + AW'(k), "R6");
      do_miss(16'h4001, 1'b1, "R6");
      stall_mode = 1'b0;
   endtask

   initial begin
      #750000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      rst_n      = 1'b0;
      miss_valid = 1'b0;
      miss_addr  = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_cold_fill();
      t_hit_refill();
      t_nonhead();
      t_pending_then_drop();
      t_wrap();
      t_stall();
      idle(10);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule